// File: doc/BRIEF.md
# Serial-Clock Hold Detector for Converter Sync and Sleep

This block sits beside the serial read-out of a delta-sigma converter. It watches the serial clock line between conversions and counts how many conversion periods in a row find that line high. The normal state of the line is low, and while it stays low the block does nothing.

A short hold on the line puts the modulator into reset. The host then releases every converter on a shared line with one common falling edge, which lines up their conversion phases. A long hold also moves the device into a low-power state. A falling edge on the line ends either state.

When the block enters reset, it asks the data-ready pin logic for a single one-clock low pulse. On release, it gives a one-clock pulse that restarts the filter settling count. While the modulator is held, the data path produces no conversion ticks. The block therefore times conversion periods itself with a free-running period counter.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: After reset, `mod_reset_o`, `power_down_o`, `pin_low_pulse_o` and `settle_restart_o` are all 0.
- R2: If the synchronised serial clock is high at fewer than `SYNC_HOLD` (default 4) consecutive conversion ticks, the block has no effect: `mod_reset_o` stays 0 and no pulse is produced.
- R3: On the conversion tick that completes `SYNC_HOLD` consecutive high periods, `mod_reset_o` goes to 1. In the same cycle, `pin_low_pulse_o` is 1 for exactly one clock, and it gives no further pulse while the hold lasts.
- R4: When the consecutive high count reaches `PDOWN_HOLD` (default 20), `power_down_o` goes to 1. Power-down is only reached through the reset state, so `power_down_o` = 1 implies `mod_reset_o` = 1.
- R5: A falling edge of the synchronised serial clock clears `mod_reset_o` and `power_down_o` together. It also pulses `settle_restart_o` high for exactly one clock, about three clocks after the pin falls (two synchroniser stages plus one register).
- R6: A tick at which the serial clock is low clears the hold count, so an interrupted hold starts counting again from zero. The count saturates at `PDOWN_HOLD`.
- R7: While `mod_reset_o` is 1, conversion periods come from an internal counter that fires every `PERIOD_CLKS` clocks, and the `conv_tick_i` input is ignored. Extra external ticks do not bring power-down sooner.
- R8: A hold that ends before `PDOWN_HOLD` periods releases the modulator without ever raising `power_down_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous to `clk` |
| conv_tick_i | input | 1 | One-clock pulse at each conversion end, from the data path |
| mod_reset_o | output | 1 | Holds the modulator in reset |
| power_down_o | output | 1 | Low-power request |
| pin_low_pulse_o | output | 1 | One-clock request to drive the data-ready pin low |
| settle_restart_o | output | 1 | One-clock pulse that restarts filter settling on release |

## Verification
The bench tries several hold patterns on the serial clock. A hold one tick too short shows that the threshold sits at the right count. A three-high, one-low, three-high pattern shows that the count restarts after a low tick. A medium hold released early separates synchronisation from power-down. A long hold, with extra external ticks driven during the reset state, shows that the internal period timer alone decides when power-down starts. Both release paths are checked for a single settle-restart pulse.

// File: rtl/sph_pkg.sv
package sph_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SLEEP = 2'd2
  } sph_state_e;
endpackage

// File: rtl/sph_sclk_sync.sv
module sph_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sph_period_timer.sv
module sph_period_timer #(
  parameter int PERIOD_CLKS = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign int_tick = (cnt_q == LAST);
  assign tick_o   = held_i ? int_tick : ext_tick_i;

  AST_HELD_IGNORES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (held_i && !int_tick) |-> !tick_o); // R7
endmodule

// File: rtl/sph_hold_fsm.sv
module sph_hold_fsm
  import sph_pkg::*;
#(
  parameter int SYNC_HOLD  = 4,
  parameter int PDOWN_HOLD = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic fall_i,
  input  logic tick_i,
  output logic held_o,
  output logic sleep_o,
  output logic low_pulse_o,
  output logic settle_o
);
  localparam int HW = $clog2(PDOWN_HOLD + 1);
  localparam logic [HW-1:0] SYNC_M1 = HW'(SYNC_HOLD - 1);
  localparam logic [HW-1:0] PD_M1   = HW'(PDOWN_HOLD - 1);
  localparam logic [HW-1:0] PD_MAX  = HW'(PDOWN_HOLD);

  sph_state_e    state_q;
  logic [HW-1:0] hold_q;
  logic          low_q, settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      hold_q   <= '0;
      low_q    <= 1'b0;
      settle_q <= 1'b0;
    end else begin
      low_q    <= 1'b0;
      settle_q <= 1'b0;
      if (fall_i) begin
        hold_q <= '0;
        if (state_q != ST_RUN) begin
          state_q  <= ST_RUN;
          settle_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (!level_i)             hold_q <= '0;
        else if (hold_q < PD_MAX) hold_q <= hold_q + 1'b1;
        if (level_i && state_q == ST_RUN && hold_q == SYNC_M1) begin
          state_q <= ST_HOLD;
          low_q   <= 1'b1;
        end
        if (level_i && state_q == ST_HOLD && hold_q == PD_M1)
          state_q <= ST_SLEEP;
      end
    end
  end

  assign held_o      = (state_q != ST_RUN);
  assign sleep_o     = (state_q == ST_SLEEP);
  assign low_pulse_o = low_q;
  assign settle_o    = settle_q;

  AST_HOLD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= PD_MAX); // R6
  AST_SLEEP_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> held_o); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    low_pulse_o |=> !low_pulse_o); // R3
  AST_PULSE_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_o) |-> low_pulse_o); // R3
  AST_RELEASE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_o) |-> settle_o); // R5
  AST_SLEEP_VIA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(held_o)); // R4
endmodule

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl #(
  parameter int SYNC_HOLD   = 4,
  parameter int PDOWN_HOLD  = 20,
  parameter int PERIOD_CLKS = 384,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic conv_tick_i,
  output logic mod_reset_o,
  output logic power_down_o,
  output logic pin_low_pulse_o,
  output logic settle_restart_o
);
  logic level, fall, tick, held;

  sph_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sclk_i),
    .level_o(level), .fall_o(fall)
  );

  sph_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .held_i(held),
    .ext_tick_i(conv_tick_i), .tick_o(tick)
  );

  sph_hold_fsm #(.SYNC_HOLD(SYNC_HOLD), .PDOWN_HOLD(PDOWN_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .level_i(level), .fall_i(fall), .tick_i(tick),
    .held_o(held), .sleep_o(power_down_o),
    .low_pulse_o(pin_low_pulse_o), .settle_o(settle_restart_o)
  );

  assign mod_reset_o = held;
endmodule

// File: tb/tb_sclk_hold_ctrl.sv
`timescale 1ns/1ps
module tb_sclk_hold_ctrl;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic tick = 1'b0;
  logic mod_rst, pd, lowp, settle;
  int checks = 0, fails = 0;
  int low_cnt = 0, settle_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sclk_hold_ctrl #(.SYNC_HOLD(4), .PDOWN_HOLD(20), .PERIOD_CLKS(P), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .conv_tick_i(tick),
    .mod_reset_o(mod_rst), .power_down_o(pd),
    .pin_low_pulse_o(lowp), .settle_restart_o(settle)
  );

  always @(negedge clk) begin
    if (lowp)   low_cnt++;
    if (settle) settle_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ext_periods(input int n);
    for (int i = 0; i < n; i++) begin
      clocks(P - 1);
      pulse_tick();
    end
  endtask

  task automatic set_sclk(input logic v);
    @(negedge clk) sclk = v;
    clocks(5);
  endtask

  task automatic t_reset();
    chk("R1 mod_reset", mod_rst, 0);
    chk("R1 power_down", pd, 0);
    chk("R1 low pulse", low_cnt, 0);
    chk("R1 settle", settle_cnt, 0);
  endtask

  task automatic t_short_hold();
    low_cnt = 0;
    ext_periods(3);
    set_sclk(1'b1);
    ext_periods(3);
    clocks(3);
    chk("R2 mod_reset after 3", mod_rst, 0);
    chk("R2 no low pulse", low_cnt, 0);
    set_sclk(1'b0);
  endtask

  task automatic t_interrupted();
    low_cnt = 0;
    set_sclk(1'b1);
    ext_periods(3);
    set_sclk(1'b0);
    ext_periods(1);
    set_sclk(1'b1);
    ext_periods(3);
    clocks(3);
    chk("R6 count restarted", mod_rst, 0);
    ext_periods(1);
    clocks(2);
    chk("R3 mod_reset at 4th", mod_rst, 1);
    chk("R3 one low pulse", low_cnt, 1);
    chk("R8 no power_down", pd, 0);
    settle_cnt = 0;
    set_sclk(1'b0);
    chk("R5 released", mod_rst, 0);
    chk("R5 settle pulse", settle_cnt, 1);
    ext_periods(2);
  endtask

  task automatic t_sync_release();
    low_cnt = 0;
    settle_cnt = 0;
    set_sclk(1'b1);
    ext_periods(4);
    clocks(2);
    chk("R3 enter reset", mod_rst, 1);
    chk("R3 pulse count", low_cnt, 1);
    clocks(8 * P);
    chk("R3 still one pulse", low_cnt, 1);
    chk("R8 no power_down mid hold", pd, 0);
    set_sclk(1'b0);
    chk("R5 reset cleared", mod_rst, 0);
    chk("R8 power_down never set", pd, 0);
    chk("R5 single settle", settle_cnt, 1);
    ext_periods(2);
  endtask

  task automatic t_power_down();
    low_cnt = 0;
    settle_cnt = 0;
    set_sclk(1'b1);
    ext_periods(4);
    clocks(1);
    chk("R3 enter reset", mod_rst, 1);
    for (int i = 0; i < 55; i++) begin
      pulse_tick();
      clocks(2);
    end
    chk("R7 ext ticks ignored", pd, 0);
    clocks(3 * P);
    chk("R4 power_down", pd, 1);
    chk("R4 reset held", mod_rst, 1);
    chk("R4 one low pulse", low_cnt, 1);
    set_sclk(1'b0);
    chk("R5 power_down cleared", pd, 0);
    chk("R5 reset cleared", mod_rst, 0);
    chk("R5 settle once", settle_cnt, 1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(2);
    t_reset();
    t_short_hold();
    t_interrupted();
    t_sync_release();
    t_power_down();
    summary();
  end
endmodule